// File: doc/BRIEF.md
# Link Register and Code-Fetch Unit

This block holds a 20-bit return address spread over three link registers: a 4-bit extension, a high byte and a low byte. A link command copies the program counter into them. A return command presents the stored value as the program counter to resume at. The same registers also act as a pointer into program memory. A code-load command reads the 16-bit word at that pointer into a pair of table-buffer bytes. A post-increment form of the load also steps the low link byte once the access has finished.

A mode pin limits the program space to 64K words. While the pin is low, the extension register is left alone and the top four bits of both the returned program counter and the memory address read as zero. Program memory is reached through a single-cycle request pulse. The unit then waits for a valid strobe, which arrives one cycle later in the intended system. A busy flag covers the time the load is outstanding.

Top module: `lnk_fetch_unit`

## Requirements
- R1: A link command (cmdOp = 1) accepted while idle with wideSpace high loads linkExt with pcIn[19:16], linkHi with pcIn[15:8] and linkLo with pcIn[7:0] at the next clock edge.
- R2: While idle, a return command (cmdOp = 2) raises retValid in the same cycle. retPc is built as {extension, high, low}. retValid is low in every other cycle.
- R3: A load command (cmdOp = 3, or 4 for post-increment) accepted while idle drives memReq high for exactly one cycle, the cycle after acceptance. memAddr carries {extension, high, low}.
- R4: The table buffer is written only at the edge where memValid is high while a load waits for its data: tbHi takes memData[15:8] and tbLo takes memData[7:0]. memValid at any other time leaves both bytes unchanged.
- R5: The post-increment load (cmdOp = 4) adds one to linkLo at the edge where the data is taken. The step wraps from 0xFF to 0x00 and never changes linkHi.
- R6: With wideSpace low, a link command updates linkHi and linkLo but leaves linkExt unchanged.
- R7: With wideSpace low, retPc[19:16] and memAddr[19:16] are zero. Raising wideSpace again exposes the stored extension.
- R8: busy is high from the edge that accepts a load until the edge that takes its data. Any command presented while busy is ignored.
- R9: The plain load (cmdOp = 3) leaves all link registers unchanged.
- R10: After reset the link registers and table buffer are zero, and busy and memReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOp | input | 3 | Command: 0 none, 1 link, 2 return, 3 load, 4 load with post-increment |
| pcIn | input | 20 | Program counter captured by a link command |
| wideSpace | input | 1 | High: full 20-bit program space; low: 64K-word space |
| memValid | input | 1 | Program memory read data valid |
| memData | input | 16 | Program memory read data |
| memReq | output | 1 | Program memory read request, one-cycle pulse |
| memAddr | output | 20 | Program memory read address |
| retPc | output | 20 | Restored program counter |
| retValid | output | 1 | Return command accepted this cycle |
| busy | output | 1 | Code load outstanding |
| linkExt | output | 4 | Extension link register |
| linkHi | output | 8 | High link register |
| linkLo | output | 8 | Low link register |
| tbHi | output | 8 | Table buffer high byte |
| tbLo | output | 8 | Table buffer low byte |

## Verification
Link, return and load are run under both settings of the mode pin. A link captures a different extension each time, so a dropped or wrongly gated extension write shows up in the registers and the address. A load with post-increment starts from a low byte of 0xFF, which separates a wrap from a carry into the high byte. Plain loads separate the two load forms. Commands sent during a load with a longer memory delay, and a stray valid strobe while idle, test the busy gating and the table-buffer write enable. A behavioural reference model is compared with every output on every cycle.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_LINK     = 3'd1,
    OP_RETURN   = 3'd2,
    OP_LOAD     = 3'd3,
    OP_LOAD_INC = 3'd4
  } lnk_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureLink;
    logic captureExt;
    logic loadTb;
    logic incLo;
  } lnk_stb_t;
endpackage

// File: rtl/lnk_ctrl.sv
`timescale 1ns/1ps
module lnk_ctrl
  import lnk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cmdOp,
  input  logic       wideSpace,
  input  logic       memValid,
  output lnk_stb_t   stb,
  output logic       memReq,
  output logic       busy,
  output logic       retValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fetch_st_e;

  fetch_st_e stateQ, stateD;
  logic      incPendQ;
  logic      accept;
  logic      startLoad;
  logic      done;

  assign accept    = (stateQ == ST_IDLE);
  assign startLoad = accept && (cmdOp == OP_LOAD || cmdOp == OP_LOAD_INC);
  assign done      = (stateQ == ST_WAIT) && memValid;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startLoad) stateD = ST_REQ;
      ST_REQ:  stateD = ST_WAIT;
      ST_WAIT: if (memValid) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      incPendQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (startLoad) incPendQ <= (cmdOp == OP_LOAD_INC);
    end
  end

  always_comb begin
    stb.captureLink = accept && (cmdOp == OP_LINK);
    stb.captureExt  = accept && (cmdOp == OP_LINK) && wideSpace;
    stb.loadTb      = done;
    stb.incLo       = done && incPendQ;
  end

  assign memReq   = (stateQ == ST_REQ);
  assign busy     = !accept;
  assign retValid = accept && (cmdOp == OP_RETURN);
endmodule

// File: rtl/lnk_dpath.sv
`timescale 1ns/1ps
module lnk_dpath
  import lnk_pkg::*;
#(
  parameter int EXT_W = 4,
  parameter int SEG_W = 8,
  localparam int ADDR_W = EXT_W + 2 * SEG_W,
  localparam int WORD_W = 2 * SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lnk_stb_t          stb,
  input  logic              wideSpace,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] memData,
  output logic [EXT_W-1:0]  linkExt,
  output logic [SEG_W-1:0]  linkHi,
  output logic [SEG_W-1:0]  linkLo,
  output logic [SEG_W-1:0]  tbHi,
  output logic [SEG_W-1:0]  tbLo,
  output logic [ADDR_W-1:0] linkAddr
);
  logic [EXT_W-1:0] extQ;
  logic [SEG_W-1:0] hiQ, loQ, tbHiQ, tbLoQ;
  logic [EXT_W-1:0] extEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ  <= '0;
      hiQ   <= '0;
      loQ   <= '0;
      tbHiQ <= '0;
      tbLoQ <= '0;
    end else begin
      if (stb.captureExt) extQ <= pcIn[ADDR_W-1 -: EXT_W];
      if (stb.captureLink) begin
        hiQ <= pcIn[2*SEG_W-1 -: SEG_W];
        loQ <= pcIn[SEG_W-1:0];
      end else if (stb.incLo) begin
        loQ <= loQ + 1'b1;
      end
      if (stb.loadTb) begin
        tbHiQ <= memData[WORD_W-1 -: SEG_W];
        tbLoQ <= memData[SEG_W-1:0];
      end
    end
  end

  // top address bits forced inactive in the 64K-word space
  assign extEff   = wideSpace ? extQ : {EXT_W{1'b0}};
  assign linkAddr = {extEff, hiQ, loQ};
  assign linkExt  = extQ;
  assign linkHi   = hiQ;
  assign linkLo   = loQ;
  assign tbHi     = tbHiQ;
  assign tbLo     = tbLoQ;
endmodule

// File: rtl/lnk_fetch_unit.sv
`timescale 1ns/1ps
module lnk_fetch_unit
  import lnk_pkg::*;
#(
  parameter int EXT_W = 4,
  parameter int SEG_W = 8,
  localparam int ADDR_W = EXT_W + 2 * SEG_W,
  localparam int WORD_W = 2 * SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              wideSpace,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] retPc,
  output logic              retValid,
  output logic              busy,
  output logic [EXT_W-1:0]  linkExt,
  output logic [SEG_W-1:0]  linkHi,
  output logic [SEG_W-1:0]  linkLo,
  output logic [SEG_W-1:0]  tbHi,
  output logic [SEG_W-1:0]  tbLo
);
  lnk_stb_t          stb;
  logic [ADDR_W-1:0] linkAddr;

  lnk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .wideSpace(wideSpace),
    .memValid(memValid), .stb(stb), .memReq(memReq), .busy(busy),
    .retValid(retValid)
  );

  lnk_dpath #(.EXT_W(EXT_W), .SEG_W(SEG_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wideSpace(wideSpace),
    .pcIn(pcIn), .memData(memData), .linkExt(linkExt), .linkHi(linkHi),
    .linkLo(linkLo), .tbHi(tbHi), .tbLo(tbLo), .linkAddr(linkAddr)
  );

  assign memAddr = linkAddr;
  assign retPc   = linkAddr;
endmodule

// File: rtl/lnk_fetch_chk.sv
`timescale 1ns/1ps
module lnk_fetch_chk #(
  parameter int EXT_W = 4,
  parameter int SEG_W = 8,
  localparam int ADDR_W = EXT_W + 2 * SEG_W,
  localparam int WORD_W = 2 * SEG_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cmdOp,
  input logic [ADDR_W-1:0] pcIn,
  input logic              wideSpace,
  input logic              memValid,
  input logic [WORD_W-1:0] memData,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] retPc,
  input logic              retValid,
  input logic              busy,
  input logic [EXT_W-1:0]  linkExt,
  input logic [SEG_W-1:0]  linkHi,
  input logic [SEG_W-1:0]  linkLo,
  input logic [SEG_W-1:0]  tbHi,
  input logic [SEG_W-1:0]  tbLo
);
  a_r1_link_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdOp == 3'd1) |=> (linkHi == $past(pcIn[2*SEG_W-1 -: SEG_W])
                                 && linkLo == $past(pcIn[SEG_W-1:0])));

  a_r2_ret_idle: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> (!busy && retPc == memAddr));

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (!memReq && busy));

  a_r4_tb_hold: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |=> $stable({tbHi, tbLo}));

  a_r4_tb_load: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReq && memValid) |=> ({tbHi, tbLo} == $past(memData)));

  a_r5_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memValid) |=> $stable(linkHi));

  a_r6_ext_kept: assert property (@(posedge clk) disable iff (!rstN)
    !wideSpace |=> $stable(linkExt));

  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memValid) |=> $stable({linkExt, linkHi, linkLo}));
endmodule

bind lnk_fetch_unit lnk_fetch_chk #(.EXT_W(EXT_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/sim_lnk_fetch_unit.sv
`timescale 1ns/1ps
module sim_lnk_fetch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [19:0] pcIn = '0;
  logic        wideSpace = 1'b1;
  logic        memValidR = 1'b0;
  logic        spur = 1'b0;
  logic        memValid;
  logic [15:0] memData = '0;
  logic        memReq, retValid, busy;
  logic [19:0] memAddr, retPc;
  logic [3:0]  linkExt;
  logic [7:0]  linkHi, linkLo, tbHi, tbLo;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;
  assign memValid = memValidR | spur;

  lnk_fetch_unit u0 (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .pcIn(pcIn), .wideSpace(wideSpace),
    .memValid(memValid), .memData(memData), .memReq(memReq), .memAddr(memAddr),
    .retPc(retPc), .retValid(retValid), .busy(busy), .linkExt(linkExt),
    .linkHi(linkHi), .linkLo(linkLo), .tbHi(tbHi), .tbLo(tbLo)
  );

  function automatic logic [15:0] romWord(logic [19:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + {4'h0, a[19:16]}};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // program memory: answers memLat cycles after a request
  int memLat = 1;
  int memCnt = 0;
  logic [19:0] memAddrCap = '0;
  always @(negedge clk) begin
    memValidR = 1'b0;
    if (memCnt > 0) begin
      memCnt--;
      if (memCnt == 0) begin
        memValidR = 1'b1;
        memData   = romWord(memAddrCap);
      end
    end
    if (memReq) begin
      memCnt     = memLat;
      memAddrCap = memAddr;
    end
  end

  // behavioural reference model, updated at each rising edge
  int mExt = 0, mHi = 0, mLo = 0, mTb = 0, mState = 0, mInc = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mExt = 0; mHi = 0; mLo = 0; mTb = 0; mState = 0; mInc = 0;
    end else if (mState == 0) begin
      if (cmdOp == 3'd1) begin
        mHi = int'(pcIn[15:8]);
        mLo = int'(pcIn[7:0]);
        if (wideSpace) mExt = int'(pcIn[19:16]);
      end else if (cmdOp == 3'd3 || cmdOp == 3'd4) begin
        mState = 1;
        mInc   = (cmdOp == 3'd4) ? 1 : 0;
      end
    end else if (mState == 1) begin
      mState = 2;
    end else if (memValid) begin
      mTb = int'(memData);
      if (mInc != 0) mLo = (mLo + 1) % 256;
      mState = 0;
    end
  end

  // every-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      int addr;
      addr = ((wideSpace ? mExt : 0) << 16) | (mHi << 8) | mLo;
      chk("R1", "linkHi", linkHi, mHi);
      chk("R6", "linkExt", linkExt, mExt);
      chk("R5", "linkLo", linkLo, mLo);
      chk("R2", "retPc", retPc, addr);
      chk("R2", "retValid", retValid, (mState == 0 && cmdOp == 3'd2) ? 1 : 0);
      chk("R3", "memReq", memReq, (mState == 1) ? 1 : 0);
      chk("R7", "memAddr", memAddr, addr);
      chk("R4", "tableBuf", {tbHi, tbLo}, mTb);
      chk("R8", "busy", busy, (mState != 0) ? 1 : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitIdle();
    while (busy) step(1);
  endtask

  task automatic doLink(logic [19:0] pc);
    cmdOp = 3'd1; pcIn = pc;
    step(1);
    cmdOp = 3'd0;
    #0.5;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      nFails++;
      $display("FAIL R8 watchdog expired actual=%0d expected<=5000", cyc);
      finishRun();
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    #0.5;
    // R10 reset state
    chk("R10", "linkExt", linkExt, 0);
    chk("R10", "linkHi/Lo", {linkHi, linkLo}, 0);
    chk("R10", "tableBuf", {tbHi, tbLo}, 0);
    chk("R10", "busy/memReq", {busy, memReq}, 0);

    // R1 link capture
    doLink(20'hABCDE);
    chk("R1", "link regs", {linkExt, linkHi, linkLo}, 20'hABCDE);

    // R2 return
    cmdOp = 3'd2; #0.5;
    chk("R2", "retValid", retValid, 1);
    chk("R2", "retPc", retPc, 20'hABCDE);
    step(1); cmdOp = 3'd0; #0.5;
    chk("R2", "retValid after", retValid, 0);

    // R3 / R9 plain load
    cmdOp = 3'd3; step(1); cmdOp = 3'd0; #0.5;
    chk("R3", "memReq", memReq, 1);
    chk("R3", "memAddr", memAddr, 20'hABCDE);
    step(1);
    chk("R3", "memReq pulse end", memReq, 0);
    waitIdle();
    chk("R4", "tableBuf", {tbHi, tbLo}, romWord(20'hABCDE));
    chk("R9", "link regs kept", {linkExt, linkHi, linkLo}, 20'hABCDE);

    // R5 post-increment wrap without carry
    doLink(20'h123FF);
    cmdOp = 3'd4; step(1); cmdOp = 3'd0;
    waitIdle();
    chk("R5", "linkLo wrapped", linkLo, 8'h00);
    chk("R5", "linkHi no carry", linkHi, 8'h23);
    chk("R4", "tableBuf inc", {tbHi, tbLo}, romWord(20'h123FF));

    // R8 commands ignored while a slow load is outstanding
    memLat = 3;
    cmdOp = 3'd3; step(1);
    cmdOp = 3'd1; pcIn = 20'h98765;
    chk("R8", "busy", busy, 1);
    waitIdle();
    cmdOp = 3'd0; #0.5;
    chk("R8", "link regs kept", {linkExt, linkHi, linkLo}, 20'h12300);
    chk("R8", "tableBuf", {tbHi, tbLo}, romWord(20'h12300));
    memLat = 1;

    // R4 stray valid while idle
    spur = 1'b1; step(1); spur = 1'b0; #0.5;
    chk("R4", "tableBuf stray valid", {tbHi, tbLo}, romWord(20'h12300));

    // R6 / R7 64K-word space
    wideSpace = 1'b0;
    doLink(20'hF5566);
    chk("R6", "linkExt kept", linkExt, 4'h1);
    chk("R6", "linkHi/Lo", {linkHi, linkLo}, 16'h5566);
    chk("R7", "memAddr masked", memAddr, 20'h05566);
    cmdOp = 3'd3; step(1); cmdOp = 3'd0; #0.5;
    chk("R7", "memAddr on req", memAddr, 20'h05566);
    waitIdle();
    chk("R7", "tableBuf narrow", {tbHi, tbLo}, romWord(20'h05566));
    cmdOp = 3'd2; #0.5;
    chk("R7", "retPc masked", retPc, 20'h05566);
    step(1); cmdOp = 3'd0;
    wideSpace = 1'b1; #0.5;
    chk("R7", "retPc wide again", retPc, 20'h15566);
    step(2);
    finishRun();
  end
endmodule